// File: doc/BRIEF.md
# Programmable Three-Port Parallel Interface

This block gives a host three 8-bit parallel ports, called A, B and C, and one write-only control register. A 2-bit address selects the target of each access. Writing a data address loads that port's output register. Its pins always present that register, together with a per-bit output enable.

The control address takes two word formats, and bit 7 tells them apart. When bit 7 is high, the word defines the operating modes and the direction of each port group. When bit 7 is low, the word sets or clears one bit of port C. A read of a port merges two sources bit by bit: the external pin value on bits configured as inputs, and the output register on bits configured as outputs. The port modes are brought out so that a companion handshake block can follow them.

Top module: `tri_port_pio`

## Requirements
- R1: A write with `wr_i` high to address 0, 1 or 2 loads `wdata_i` into the output register of port A, B or C respectively, visible on that port's pins after the same clock edge. The other ports' registers are unchanged.
- R2: A read of address 3 returns 0xFF on `rdata_o`.
- R3: A read of port address 0, 1 or 2 returns, per bit, the pin input where that bit is an input and the output register where it is an output.
- R4: A control word with bit 7 = 1 sets the port A mode to 2 when bit 6 = 1, whatever bit 5 is. Otherwise the port A mode equals bit 5. The port B mode equals bit 2. `mode_a_o` never shows 3.
- R5: In a control word with bit 7 = 1, bit 4 = 1 makes all of port A input, bit 1 makes all of port B input, bit 3 makes C[7:4] input and bit 0 makes C[3:0] input. A bit left at 0 makes its group output. Port A is all input whenever its mode is 2.
- R6: A control word with bit 7 = 0 writes bit 0 of the word into port C output bit number word[3:1]. All other port C bits, every mode and every direction stay unchanged.
- R7: After reset all output registers are 0x00, both modes are 0, every bit is an input (all output enables 0) and `rdata_o` is 0x00.
- R8: With parameter CLEAR_ON_MODE = 1, a control word with bit 7 = 1 clears all three output registers to 0x00. With the default value 0, the output registers keep their values.
- R9: Each port's output enable is high exactly on the bits configured as outputs.
- R10: `rdata_o` is registered. It takes the read value on the clock edge where `rd_i` is high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Address: 0 = A, 1 = B, 2 = C, 3 = control |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pa_i | input | 8 | Port A pin input |
| pb_i | input | 8 | Port B pin input |
| pc_i | input | 8 | Port C pin input |
| pa_o | output | 8 | Port A output register |
| pb_o | output | 8 | Port B output register |
| pc_o | output | 8 | Port C output register |
| pa_oe_o | output | 8 | Port A per-bit output enable |
| pb_oe_o | output | 8 | Port B per-bit output enable |
| pc_oe_o | output | 8 | Port C per-bit output enable |
| mode_a_o | output | 2 | Port A mode (0, 1 or 2) |
| mode_b_o | output | 1 | Port B mode (0 or 1) |

## Verification
The hardest case to reach is a port C read where the two nibbles have different directions. Such a read only shows a merge error when the pin value and the output register differ on both halves. The stimulus first sets a split-direction mode, then loads port C with a pattern complementary to the pin pattern, so that each nibble can only be correct from its own source. The single-bit control format is driven at both index ends (bit 0 and bit 7), and with both set and clear values, on top of known register contents. This shows that exactly one bit moves while directions and modes stay put.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NPORTS  = 3;
  localparam int unsigned IDX_W   = $clog2(DATA_W);
  localparam int unsigned HALF_W  = DATA_W / 2;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    MODE_BASIC  = 2'd0,
    MODE_STROBE = 2'd1,
    MODE_BIDIR  = 2'd2
  } mode_a_e;

  // control word field positions (bit 7 selects format)
  localparam int unsigned CW_FMT   = 7;
  localparam int unsigned CW_A_BI  = 6;
  localparam int unsigned CW_A_STB = 5;
  localparam int unsigned CW_A_IN  = 4;
  localparam int unsigned CW_CH_IN = 3;
  localparam int unsigned CW_B_STB = 2;
  localparam int unsigned CW_B_IN  = 1;
  localparam int unsigned CW_CL_IN = 0;

  function automatic logic [DATA_W-1:0] merge_rd(
      input logic [DATA_W-1:0] pin,
      input logic [DATA_W-1:0] outr,
      input logic [DATA_W-1:0] in_mask);
    return (pin & in_mask) | (outr & ~in_mask);
  endfunction
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output mode_a_e           mode_a_o,
  output logic              mode_b_o,
  output logic [DATA_W-1:0] mask_a_o,
  output logic [DATA_W-1:0] mask_b_o,
  output logic [DATA_W-1:0] mask_c_o,
  output logic              def_wr_o,
  output logic              bsr_wr_o,
  output logic [IDX_W-1:0]  bsr_idx_o,
  output logic              bsr_val_o
);
  mode_a_e           mode_a_q, mode_a_d;
  logic              mode_b_q;
  logic [DATA_W-1:0] mask_a_q, mask_b_q, mask_c_q;

  assign def_wr_o  = ctrl_wr_i &  wdata_i[CW_FMT];
  assign bsr_wr_o  = ctrl_wr_i & ~wdata_i[CW_FMT];
  assign bsr_idx_o = wdata_i[IDX_W:1];
  assign bsr_val_o = wdata_i[0];

  always_comb begin
    if (wdata_i[CW_A_BI])       mode_a_d = MODE_BIDIR;
    else if (wdata_i[CW_A_STB]) mode_a_d = MODE_STROBE;
    else                        mode_a_d = MODE_BASIC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_a_q <= MODE_BASIC;
      mode_b_q <= 1'b0;
      mask_a_q <= '1;
      mask_b_q <= '1;
      mask_c_q <= '1;
    end else if (def_wr_o) begin
      mode_a_q <= mode_a_d;
      mode_b_q <= wdata_i[CW_B_STB];
      mask_a_q <= (wdata_i[CW_A_BI] || wdata_i[CW_A_IN]) ? '1 : '0;
      mask_b_q <= wdata_i[CW_B_IN] ? '1 : '0;
      mask_c_q <= {{HALF_W{wdata_i[CW_CH_IN]}}, {HALF_W{wdata_i[CW_CL_IN]}}};
    end
  end

  assign mode_a_o = mode_a_q;
  assign mode_b_o = mode_b_q;
  assign mask_a_o = mask_a_q;
  assign mask_b_o = mask_b_q;
  assign mask_c_o = mask_c_q;

  assert_mode_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_a_q != 2'd3);
  assert_bidir_input_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_a_q == MODE_BIDIR) |-> (mask_a_q == '1));
  assert_bsr_keeps_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bsr_wr_o |=> ($stable(mask_a_q) && $stable(mask_b_q) && $stable(mask_c_q)
                  && $stable(mode_a_q) && $stable(mode_b_q)));
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter bit HAS_BSR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              bit_en_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic              bit_val_i,
  input  logic [DATA_W-1:0] pin_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic [DATA_W-1:0] out_o,
  output logic [DATA_W-1:0] oe_o,
  output logic [DATA_W-1:0] rd_val_o
);
  logic [DATA_W-1:0] out_q, out_d;
  logic              bit_op;

  generate
    if (HAS_BSR) begin : g_bsr
      assign bit_op = bit_en_i;
    end else begin : g_nobsr
      assign bit_op = 1'b0;
    end
  endgenerate

  always_comb begin
    out_d = out_q;
    if (clr_i)        out_d = '0;
    else if (wr_en_i) out_d = wdata_i;
    else if (bit_op)  out_d[bit_idx_i] = bit_val_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign out_o    = out_q;
  assign oe_o     = ~mask_i;
  assign rd_val_o = merge_rd(pin_i, out_q, mask_i);

  assert_out_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !clr_i && !bit_op) |=> $stable(out_q));
  assert_bsr_one_bit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_op && !wr_en_i && !clr_i) |=> ($countones(out_q ^ $past(out_q)) <= 1));
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
  import pio_pkg::*;
#(
  parameter bit CLEAR_ON_MODE = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] pa_i,
  input  logic [DATA_W-1:0] pb_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] pa_o,
  output logic [DATA_W-1:0] pb_o,
  output logic [DATA_W-1:0] pc_o,
  output logic [DATA_W-1:0] pa_oe_o,
  output logic [DATA_W-1:0] pb_oe_o,
  output logic [DATA_W-1:0] pc_oe_o,
  output logic [1:0]        mode_a_o,
  output logic              mode_b_o
);
  mode_a_e           mode_a;
  logic              def_wr, bsr_wr, bsr_val, port_clr;
  logic [IDX_W-1:0]  bsr_idx;
  logic [DATA_W-1:0] pin   [NPORTS];
  logic [DATA_W-1:0] mask  [NPORTS];
  logic [DATA_W-1:0] outv  [NPORTS];
  logic [DATA_W-1:0] oev   [NPORTS];
  logic [DATA_W-1:0] rdv   [NPORTS];
  logic [DATA_W-1:0] rd_d, rdata_q;

  pio_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr_i && (addr_i == SEL_CTRL)),
    .wdata_i   (wdata_i),
    .mode_a_o  (mode_a),
    .mode_b_o  (mode_b_o),
    .mask_a_o  (mask[0]),
    .mask_b_o  (mask[1]),
    .mask_c_o  (mask[2]),
    .def_wr_o  (def_wr),
    .bsr_wr_o  (bsr_wr),
    .bsr_idx_o (bsr_idx),
    .bsr_val_o (bsr_val)
  );

  assign port_clr = CLEAR_ON_MODE && def_wr;
  assign pin[0] = pa_i;
  assign pin[1] = pb_i;
  assign pin[2] = pc_i;

  for (genvar g = 0; g < NPORTS; g++) begin : g_port
    pio_port #(.HAS_BSR(g == 2)) u_port (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_i && (addr_i == 2'(g))),
      .wdata_i   (wdata_i),
      .clr_i     (port_clr),
      .bit_en_i  (bsr_wr),
      .bit_idx_i (bsr_idx),
      .bit_val_i (bsr_val),
      .pin_i     (pin[g]),
      .mask_i    (mask[g]),
      .out_o     (outv[g]),
      .oe_o      (oev[g]),
      .rd_val_o  (rdv[g])
    );
  end

  always_comb begin
    unique case (addr_i)
      SEL_A:   rd_d = rdv[0];
      SEL_B:   rd_d = rdv[1];
      SEL_C:   rd_d = rdv[2];
      default: rd_d = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_d;
  end

  assign rdata_o  = rdata_q;
  assign pa_o     = outv[0];
  assign pb_o     = outv[1];
  assign pc_o     = outv[2];
  assign pa_oe_o  = oev[0];
  assign pb_oe_o  = oev[1];
  assign pc_oe_o  = oev[2];
  assign mode_a_o = mode_a;

  assert_ctrl_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == SEL_CTRL) |=> (rdata_o == '1));
  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  assert_clear_on_def_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (CLEAR_ON_MODE && def_wr) |=> (pa_o == '0 && pb_o == '0 && pc_o == '0));
endmodule

// File: tb/tri_port_pio_tb.sv
`timescale 1ns/1ps
module tri_port_pio_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [7:0] rdata, pa, pb, pc, pa_oe, pb_oe, pc_oe;
  logic [1:0] mode_a;
  logic       mode_b;
  logic [7:0] rdata_c, pa_c, pb_c, pc_c, pa_oe_c, pb_oe_c, pc_oe_c;
  logic [1:0] mode_a_c;
  logic       mode_b_c;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tri_port_pio u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata), .pa_i(pa_in), .pb_i(pb_in), .pc_i(pc_in),
    .pa_o(pa), .pb_o(pb), .pc_o(pc), .pa_oe_o(pa_oe), .pb_oe_o(pb_oe), .pc_oe_o(pc_oe),
    .mode_a_o(mode_a), .mode_b_o(mode_b));

  tri_port_pio #(.CLEAR_ON_MODE(1'b1)) u_dut_clr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .wr_i(wr), .rd_i(rd),
    .rdata_o(rdata_c), .pa_i(pa_in), .pb_i(pb_in), .pc_i(pc_in),
    .pa_o(pa_c), .pb_o(pb_c), .pc_o(pc_c), .pa_oe_o(pa_oe_c), .pb_oe_o(pb_oe_c),
    .pc_oe_o(pc_oe_c), .mode_a_o(mode_a_c), .mode_b_o(mode_b_c));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R7 rdata", rdata, 8'h00);
    chk("R7 pa", pa, 8'h00); chk("R7 pb", pb, 8'h00); chk("R7 pc", pc, 8'h00);
    chk("R7 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    chk("R7 modes", {5'd0, mode_b, mode_a}, 8'h00);
    pa_in = 8'h5A;
    bus_rd(2'd0, d);
    chk("R3 R7 all-input read A", d, 8'h5A);
  endtask

  task automatic t_port_write();
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    chk("R9 oe all out", pa_oe & pb_oe & pc_oe, 8'hFF);
    bus_wr(2'd0, 8'h3C);
    chk("R1 pa", pa, 8'h3C);
    chk("R1 pb untouched", pb, 8'h00);
    chk("R1 pc untouched", pc, 8'h00);
    bus_wr(2'd1, 8'h96);
    chk("R1 pb", pb, 8'h96);
    chk("R1 pa untouched", pa, 8'h3C);
    pa_in = 8'hC3;
    bus_rd(2'd0, d);
    chk("R3 output read A", d, 8'h3C);
    pa_in = 8'h11;
    @(negedge clk);
    chk("R10 rdata held", rdata, 8'h3C);
  endtask

  task automatic t_modes();
    bus_wr(2'd3, 8'hE0);
    chk("R4 bit6 wins", {6'd0, mode_a}, 8'h02);
    chk("R5 mode2 A input", pa_oe, 8'h00);
    bus_wr(2'd3, 8'hA4);
    chk("R4 mode A 1", {6'd0, mode_a}, 8'h01);
    chk("R4 mode B 1", {7'd0, mode_b}, 8'h01);
    chk("R9 A out", pa_oe, 8'hFF);
    bus_wr(2'd3, 8'h92);
    chk("R5 A input", pa_oe, 8'h00);
    chk("R5 B input", pb_oe, 8'h00);
    chk("R4 mode B 0", {7'd0, mode_b}, 8'h00);
    chk("R5 C out", pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h88);
    chk("R5 C upper in", pc_oe, 8'h0F);
    bus_wr(2'd3, 8'h81);
    chk("R5 C lower in", pc_oe, 8'hF0);
  endtask

  task automatic t_split_merge();
    logic [7:0] d;
    bus_wr(2'd3, 8'h88);
    bus_wr(2'd2, 8'hA5);
    pc_in = 8'h5A;
    bus_rd(2'd2, d);
    chk("R3 split nibble C", d, 8'h55);
  endtask

  task automatic t_clear_opt();
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd2, 8'h42);
    bus_wr(2'd3, 8'h80);
    chk("R8 default keeps pa", pa, 8'h77);
    chk("R8 default keeps pc", pc, 8'h42);
    chk("R8 clear pa", pa_c, 8'h00);
    chk("R8 clear pc", pc_c, 8'h00);
  endtask

  task automatic t_bit_ops();
    bus_wr(2'd3, 8'h81);
    bus_wr(2'd2, 8'h00);
    bus_wr(2'd3, 8'h0F);
    chk("R6 set bit7", pc, 8'h80);
    bus_wr(2'd3, 8'h01);
    chk("R6 set bit0", pc, 8'h81);
    bus_wr(2'd3, 8'h0B);
    chk("R6 set bit5", pc, 8'hA1);
    bus_wr(2'd3, 8'h0E);
    chk("R6 clear bit7", pc, 8'h21);
    chk("R6 dir kept", pc_oe, 8'hF0);
    chk("R6 mode kept", {5'd0, mode_b, mode_a}, 8'h00);
    chk("R6 pa kept", pa, 8'h77);
  endtask

  task automatic t_ctrl_read();
    logic [7:0] d;
    bus_rd(2'd3, d);
    chk("R2 ctrl read", d, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_port_write();
    t_modes();
    t_split_merge();
    t_clear_opt();
    t_bit_ops();
    t_ctrl_read();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule